// File: doc/BRIEF.md
# Bridge Driver Fault Supervisor

This block watches the protection flags of a driver with several full bridges and decides when the power outputs may switch. It takes digital flags from the analog side: one overcurrent flag per bridge, an overtemperature flag, a supply undervoltage flag and a gate-supply-low flag. It also takes an active-low sleep request and a synchronous power-on reset. From these it produces a registered global output-disable, a charge-pump enable, an active-low fault indication and a one-hot record of the bridge that tripped first.

There are two kinds of fault. Undervoltage, overtemperature and gate-supply-low are self-clearing. They hold the outputs off only while the flag is present. An overcurrent is latched. It must first pass a glitch filter that counts consecutive samples. Once latched, it keeps every bridge off and pulls the fault line low until the block is reset or put to sleep. After sleep is released, or after reset, the outputs stay off for a wake-up window so the gate supply can recover.

Top module: `drv_fault_sup`

## Requirements
- R1: While `rst` is high, after the next clock edge `out_disable`=1, `pump_en`=0, `fault_n`=1 and `oc_source`=0.
- R2: While `uv_flag`=1, `out_disable` is 1 after each clock edge. If no other cause holds, it returns to 0 after the first edge at which `uv_flag` is sampled 0.
- R3: `ot_flag`=1 or `gate_low_flag`=1 sets `out_disable` after the edge that samples it. The output recovers after the first edge at which the flag is sampled 0. `fault_n` stays 1 throughout.
- R4: If `oc_flag[i]` is sampled high on OC_FILTER consecutive edges while awake, the overcurrent latch sets at the last of those edges. At that same edge `out_disable` goes to 1 and `fault_n` goes to 0.
- R5: An overcurrent pulse shorter than OC_FILTER consecutive samples has no effect. `out_disable` and `fault_n` do not change.
- R6: Once latched, the overcurrent state persists after every `oc_flag` bit returns to 0. `fault_n` stays 0 and `out_disable` stays 1.
- R7: The latch, `oc_source` and `fault_n` clear at the edge that samples `sleep_n`=0 or `rst`=1.
- R8: At the latching edge, `oc_source` gets bit i set for the tripping bridge i. When bridges trip together, the lowest index wins. Later overcurrents leave the value unchanged until it is cleared.
- R9: After an edge that samples `sleep_n`=0, `pump_en`=0 and `out_disable`=1.
- R10: After `sleep_n` rises, or after `rst` is released, `out_disable` stays 1 through the first WAKE_CYCLES edges with `sleep_n` high. If no fault is present, it drops after edge WAKE_CYCLES+1.
- R11: `fault_n` is 0 only while the overcurrent latch holds, and never while `out_disable` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| oc_flag | input | NUM_BRIDGES | Per-bridge overcurrent flags |
| ot_flag | input | 1 | Overtemperature flag |
| uv_flag | input | 1 | Supply undervoltage flag |
| gate_low_flag | input | 1 | Gate supply low flag |
| sleep_n | input | 1 | Active-low sleep request |
| out_disable | output | 1 | Forces all bridges off when 1 |
| pump_en | output | 1 | Charge-pump enable |
| fault_n | output | 1 | Active-low latched overcurrent indication |
| oc_source | output | NUM_BRIDGES | One-hot first-fault bridge record |

## Verification
The assertions check on every cycle the rules that hold at all times. A sleep request turns off the pump and the outputs. Any self-clearing flag forces the outputs off. A low fault line always comes with disabled outputs, has an overcurrent behind it, and stays low while awake. The first-fault record stays one-hot and does not move while latched. The exact edge counts can only be shown by the bench scenarios. These are the glitch filter length, the wake-up window, the priority between bridges that trip together, and the recovery cycle after a transient flag clears.

// File: rtl/drvsup_pkg.sv
package drvsup_pkg;
  typedef enum logic [1:0] {
    WK_ASLEEP = 2'd0,
    WK_SETTLE = 2'd1,
    WK_READY  = 2'd2
  } wake_state_t;
endpackage

// File: rtl/oc_glitch_filter.sv
module oc_glitch_filter #(
  parameter int FILT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_n,
  input  logic flag,
  output logic hit
);
  localparam int CW = (FILT > 1) ? $clog2(FILT) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT - 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || !sleep_n || !flag) begin
      run_cnt <= '0;
    end else if (run_cnt != LAST) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // the FILT-th consecutive high sample trips
  assign hit = sleep_n && flag && (run_cnt == LAST);
endmodule

// File: rtl/oc_trip_latch.sv
module oc_trip_latch #(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep_n,
  input  logic [NB-1:0] hit,
  output logic          latch_d,
  output logic [NB-1:0] src_q
);
  logic          latch_q;
  logic [NB-1:0] first_hit;

  // isolate lowest set bit: lowest bridge index has priority
  assign first_hit = hit & (~hit + 1'b1);

  always_comb begin
    if (rst || !sleep_n) latch_d = 1'b0;
    else                 latch_d = latch_q || (|hit);
  end

  always_ff @(posedge clk) begin
    if (rst || !sleep_n) begin
      latch_q <= 1'b0;
      src_q   <= '0;
    end else begin
      latch_q <= latch_d;
      if (!latch_q && (|hit)) src_q <= first_hit;
    end
  end
endmodule

// File: rtl/wake_timer.sv
module wake_timer
  import drvsup_pkg::*;
#(
  parameter int WAKE = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_n,
  output logic ready
);
  localparam int CW = (WAKE > 1) ? $clog2(WAKE) : 1;
  localparam logic [CW-1:0] LAST = CW'(WAKE - 1);

  wake_state_t   state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !sleep_n) begin
      state <= WK_ASLEEP;
      cnt   <= '0;
    end else begin
      unique case (state)
        WK_ASLEEP: begin
          cnt   <= CW'(1);
          state <= (WAKE == 1) ? WK_READY : WK_SETTLE;
        end
        WK_SETTLE: begin
          if (cnt == LAST) state <= WK_READY;
          else             cnt   <= cnt + 1'b1;
        end
        default: state <= WK_READY;
      endcase
    end
  end

  assign ready = (state == WK_READY);
endmodule

// File: rtl/drv_fault_sup.sv
module drv_fault_sup #(
  parameter int NUM_BRIDGES = 4,
  parameter int OC_FILTER   = 4,
  parameter int WAKE_CYCLES = 64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_BRIDGES-1:0] oc_flag,
  input  logic                   ot_flag,
  input  logic                   uv_flag,
  input  logic                   gate_low_flag,
  input  logic                   sleep_n,
  output logic                   out_disable,
  output logic                   pump_en,
  output logic                   fault_n,
  output logic [NUM_BRIDGES-1:0] oc_source
);
  logic [NUM_BRIDGES-1:0] hit;
  logic                   oc_next;
  logic                   wake_ok;
  logic                   transient;

  for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_filt
    oc_glitch_filter #(.FILT(OC_FILTER)) u_filt (
      .clk     (clk),
      .rst     (rst),
      .sleep_n (sleep_n),
      .flag    (oc_flag[b]),
      .hit     (hit[b])
    );
  end

  oc_trip_latch #(.NB(NUM_BRIDGES)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .sleep_n (sleep_n),
    .hit     (hit),
    .latch_d (oc_next),
    .src_q   (oc_source)
  );

  wake_timer #(.WAKE(WAKE_CYCLES)) u_wake (
    .clk     (clk),
    .rst     (rst),
    .sleep_n (sleep_n),
    .ready   (wake_ok)
  );

  assign transient = uv_flag || ot_flag || gate_low_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_disable <= 1'b1;
      pump_en     <= 1'b0;
      fault_n     <= 1'b1;
    end else begin
      out_disable <= !sleep_n || !wake_ok || transient || oc_next;
      pump_en     <= sleep_n;
      fault_n     <= !oc_next;
    end
  end
endmodule

// File: rtl/drv_fault_sup_chk.sv
module drv_fault_sup_chk #(
  parameter int NUM_BRIDGES = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_BRIDGES-1:0] oc_flag,
  input logic                   ot_flag,
  input logic                   uv_flag,
  input logic                   gate_low_flag,
  input logic                   sleep_n,
  input logic                   out_disable,
  input logic                   pump_en,
  input logic                   fault_n,
  input logic [NUM_BRIDGES-1:0] oc_source
);
  // R9
  sleep_off_chk: assert property (@(posedge clk) disable iff (rst)
    !sleep_n |=> (!pump_en && out_disable));
  // R2
  uv_off_chk: assert property (@(posedge clk) disable iff (rst)
    uv_flag |=> out_disable);
  // R3
  ot_off_chk: assert property (@(posedge clk) disable iff (rst)
    (ot_flag || gate_low_flag) |=> out_disable);
  // R11
  fault_with_off_chk: assert property (@(posedge clk) disable iff (rst)
    !fault_n |-> out_disable);
  // R6
  fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!fault_n && sleep_n) |=> !fault_n);
  // R4
  fault_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_n) |-> $past(oc_flag != '0));
  // R8
  src_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(oc_source));
  // R8
  src_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fault_n && sleep_n) |=> $stable(oc_source));
  // R10
  wake_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep_n) |=> out_disable);
endmodule

bind drv_fault_sup drv_fault_sup_chk #(.NUM_BRIDGES(NUM_BRIDGES)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .oc_flag       (oc_flag),
  .ot_flag       (ot_flag),
  .uv_flag       (uv_flag),
  .gate_low_flag (gate_low_flag),
  .sleep_n       (sleep_n),
  .out_disable   (out_disable),
  .pump_en       (pump_en),
  .fault_n       (fault_n),
  .oc_source     (oc_source)
);

// File: tb/drv_fault_sup_test.sv
module drv_fault_sup_test;
  localparam int NB   = 4;
  localparam int FILT = 3;
  localparam int WAKE = 6;

  typedef struct {
    bit          dis;
    bit          pump;
    bit          fn;
    logic [NB-1:0] src;
    string       req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NB-1:0] oc_flag = '0;
  logic          ot_flag = 1'b0, uv_flag = 1'b0, gate_low_flag = 1'b0;
  logic          sleep_n = 1'b1;
  logic          out_disable, pump_en, fault_n;
  logic [NB-1:0] oc_source;

  // shadow stimulus applied at the next falling edge
  logic          s_rst = 1'b1, s_ot = 1'b0, s_uv = 1'b0, s_gl = 1'b0, s_slp = 1'b1;
  logic [NB-1:0] s_oc = '0;

  int   tests = 0, fails = 0;
  bit   done = 1'b0;
  exp_t sbq[$];

  always #2 clk = ~clk;

  drv_fault_sup #(.NUM_BRIDGES(NB), .OC_FILTER(FILT), .WAKE_CYCLES(WAKE)) uut (
    .clk(clk), .rst(rst), .oc_flag(oc_flag), .ot_flag(ot_flag),
    .uv_flag(uv_flag), .gate_low_flag(gate_low_flag), .sleep_n(sleep_n),
    .out_disable(out_disable), .pump_en(pump_en), .fault_n(fault_n),
    .oc_source(oc_source)
  );

  // driver: applies stimulus and queues the outputs expected after the next edge
  task automatic step(input string req, input bit dis, input bit pump,
                      input bit fn, input logic [NB-1:0] src);
    exp_t e;
    @(negedge clk);
    rst = s_rst; oc_flag = s_oc; ot_flag = s_ot; uv_flag = s_uv;
    gate_low_flag = s_gl; sleep_n = s_slp;
    e.dis = dis; e.pump = pump; e.fn = fn; e.src = src; e.req = req;
    sbq.push_back(e);
  endtask

  // monitor: pops one expectation per rising edge, sampled 1 ns later
  always @(posedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      tests++;
      if (out_disable !== e.dis || pump_en !== e.pump || fault_n !== e.fn ||
          oc_source !== e.src) begin
        fails++;
        $display("FAIL %s: dis/pump/fault_n/src = %b/%b/%b/%b expected %b/%b/%b/%b",
                 e.req, out_disable, pump_en, fault_n, oc_source,
                 e.dis, e.pump, e.fn, e.src);
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not finish, got done=0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset values
    for (int i = 0; i < 3; i++) step("R1", 1, 0, 1, '0);
    // R2 undervoltage held through and past the wake window
    s_rst = 0; s_uv = 1;
    for (int i = 0; i < WAKE + 3; i++) step("R2", 1, 1, 1, '0);
    s_uv = 0;
    step("R2", 0, 1, 1, '0);
    // R3 overtemperature, self-clearing, fault_n untouched
    s_ot = 1;
    step("R3", 1, 1, 1, '0);
    step("R3", 1, 1, 1, '0);
    s_ot = 0;
    step("R3", 0, 1, 1, '0);
    // R3 gate supply low
    s_gl = 1;
    step("R3", 1, 1, 1, '0);
    s_gl = 0;
    step("R3", 0, 1, 1, '0);
    // R5 pulse one sample short of the filter
    s_oc = 4'b0010;
    for (int i = 0; i < FILT - 1; i++) step("R5", 0, 1, 1, '0);
    s_oc = '0;
    for (int i = 0; i < 3; i++) step("R5", 0, 1, 1, '0);
    // R4 full-length overcurrent on bridge 2
    s_oc = 4'b0100;
    for (int i = 0; i < FILT - 1; i++) step("R4", 0, 1, 1, '0);
    step("R4", 1, 1, 0, 4'b0100);
    // R6 latch persists with flags gone
    s_oc = '0;
    for (int i = 0; i < 4; i++) step("R6", 1, 1, 0, 4'b0100);
    // R8 later overcurrent on bridge 0 does not overwrite the record
    s_oc = 4'b0001;
    for (int i = 0; i < FILT + 1; i++) step("R8", 1, 1, 0, 4'b0100);
    s_oc = '0;
    // R7 and R9 sleep entry clears latch, stops pump
    s_slp = 0;
    step("R7", 1, 0, 1, '0);
    // R9 overcurrent while asleep is ignored
    s_oc = 4'b1000;
    for (int i = 0; i < FILT + 1; i++) step("R9", 1, 0, 1, '0);
    s_oc = '0;
    // R10 wake window after sleep release
    s_slp = 1;
    for (int i = 0; i < WAKE; i++) step("R10", 1, 1, 1, '0);
    step("R10", 0, 1, 1, '0);
    // R8 simultaneous trip on bridges 1 and 2: lowest wins
    s_oc = 4'b0110;
    for (int i = 0; i < FILT - 1; i++) step("R8", 0, 1, 1, '0);
    step("R8", 1, 1, 0, 4'b0010);
    s_oc = '0;
    step("R11", 1, 1, 0, 4'b0010);
    // R7 reset clears the latch too
    s_rst = 1;
    step("R7", 1, 0, 1, '0);
    s_rst = 0;
    for (int i = 0; i < WAKE; i++) step("R10", 1, 1, 1, '0);
    step("R10", 0, 1, 1, '0);
    step("R11", 0, 1, 1, '0);
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule